// File: doc/BRIEF.md
# Three-Channel Timer Bank

This block holds three 16-bit counter channels behind a small memory-mapped register window. Each channel has a count register, a mode register and a target register. Each channel advances by one on every tick from its selected source. It can flag and interrupt when it reaches its target or wraps past 0xFFFF. It can also restart from zero when it reaches the target. Each channel drives its own interrupt output as a one-cycle pulse.

Channel 0 and channel 1 count either the system tick enable or an alternate tick: the pixel tick for channel 0 and the line-blank tick for channel 1. Channel 2 counts either the system tick directly or one tick in eight through a free-running divider. Its sync field can also halt it. The bus takes a single-cycle request with an address, a write flag and a half-word flag. Read data appears on the cycle after the request.

Top module: `timer_bank`

## Requirements
- R1: Address bits 5:4 select the channel (0, 1 or 2) and bits 3:2 select the register: 0 is count, 1 is mode, 2 is target. Read data appears on `bus_rdata` in the cycle after the read request and holds until the next read.
- R2: A 32-bit write stores only bits 15:0 of the data. Every read returns the 16-bit value with bits 31:16 at zero.
- R3: A 16-bit access (`bus_half`=1) with address bit 1 set is dropped. A write of this kind changes nothing, and a read of this kind returns zero.
- R4: Channel number 3 and register number 3 read as zero, and writes to them change no register.
- R5: Channel 0 counts system ticks when mode bit 8 is 0, and pixel ticks when mode bit 8 is 1.
- R6: Channel 1 counts system ticks when mode bit 8 is 0, and line-blank ticks when mode bit 8 is 1.
- R7: Channel 2 counts system ticks when mode bit 9 is 0. When mode bit 9 is 1, it counts once for every 8 system ticks through a divider. The divider is zero at reset, advances only while bit 9 is set, and keeps its remainder.
- R8: Channel 2 holds its count when mode bit 0 (sync enable) is 1 and mode bits 2:1 are 0 or 3. It counts when those bits are 1 or 2, or when bit 0 is 0.
- R9: On each tick the count rises by one. Reaching a nonzero target sets mode bit 11. With mode bit 3 set, reaching the target also restarts the count at 0. Passing from 0xFFFF to 0 sets mode bit 12. A mode read clears bits 11 and 12. A mode write stores bits 9:0 and clears the count.
- R10: An event is a target hit with mode bit 4 set, or a wrap with mode bit 5 set.
  - Without mode bit 6 (repeat), only the first event after a mode write acts.
  - An acting event inverts mode bit 10 (the active-low request line) when mode bit 7 is set. Otherwise it pulses bit 10 low and the line returns to 1.
  - Each fall of bit 10 gives a one-cycle pulse on `irq_out[channel]` in the cycle after the tick.
  - A mode write with data bit 10 set forces bit 10 to 1.
- R11: After reset all counts and targets are 0, every mode reads 0x0400, and `irq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_tick | input | 1 | System tick enable |
| pix_tick | input | 1 | Pixel tick, alternate source of channel 0 |
| hbl_tick | input | 1 | Line-blank tick, alternate source of channel 1 |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_half | input | 1 | 1 for a 16-bit access, 0 for 32-bit |
| bus_addr | input | 6 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_out | output | 3 | One-cycle interrupt pulse per channel |

## Verification
The assertions check on every cycle that:
- dropped upper-half reads and reads of channel 3 return zero;
- read data never has upper bits set;
- a dropped write leaves the targets unchanged;
- a halted channel 2 holds its count;
- no interrupt pulse appears without a tick from that channel's possible sources in the cycle before.

Only the bench scenarios can show the rest:
- the source choice per channel;
- the divide-by-eight rate and its kept remainder;
- restart at target;
- wrap flags and their clear on read;
- one-shot suppression, and toggle mode giving a pulse only on every second event.

// File: rtl/timer_bank.sv
module timer_bank #(
  parameter int CW      = 16,
  parameter int DW      = 32,
  parameter int AW      = 6,
  parameter int PRE_DIV = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_tick,
  input  logic          pix_tick,
  input  logic          hbl_tick,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic          bus_half,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [2:0]    irq_out
);
  localparam int NCH = 3;
  localparam int MW  = 13;
  localparam int PW  = $clog2(PRE_DIV);

  logic [1:0] sel_ch, sel_reg;
  logic       drop, wr, rd;
  assign sel_ch  = bus_addr[5:4];
  assign sel_reg = bus_addr[3:2];
  assign drop    = bus_half && bus_addr[1];
  assign wr      = bus_valid && bus_write && !drop;
  assign rd      = bus_valid && !bus_write;

  wire unused_ok = ^{bus_addr[0], bus_wdata[DW-1:CW]};

  logic [NCH-1:0][CW-1:0] cnt_v, tgt_v;
  logic [NCH-1:0][MW-1:0] mode_v;
  logic [NCH-1:0]         tick;

  logic [PW-1:0] pre;
  logic          pre_run, pre_tick, halt2;
  assign pre_run  = mode_v[2][9];
  assign pre_tick = pre_run && sys_tick && (pre == PW'(PRE_DIV-1));
  assign halt2    = mode_v[2][0] && (mode_v[2][2:1] == 2'd0 || mode_v[2][2:1] == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n)                pre <= '0;
    else if (pre_run && sys_tick) pre <= (pre == PW'(PRE_DIV-1)) ? '0 : pre + 1'b1;
  end

  assign tick[0] = mode_v[0][8] ? pix_tick : sys_tick;
  assign tick[1] = mode_v[1][8] ? hbl_tick : sys_tick;
  assign tick[2] = !halt2 && (mode_v[2][9] ? pre_tick : sys_tick);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CW-1:0] cnt_q, tgt_q, nxt;
    logic [MW-1:0] mode_q;
    logic          fired_q, irq_q;
    logic          wbusy, rd_mode, at_tgt, wrap, ev, fire, nirq_nxt, strobe;

    assign wbusy    = wr && sel_ch == 2'(g) && sel_reg != 2'd3;
    assign rd_mode  = rd && sel_ch == 2'(g) && sel_reg == 2'd1;
    assign nxt      = cnt_q + 1'b1;
    assign at_tgt   = tick[g] && nxt == tgt_q && tgt_q != '0;
    assign wrap     = tick[g] && &cnt_q;
    assign ev       = (at_tgt && mode_q[4]) || (wrap && mode_q[5]);
    assign fire     = ev && !(fired_q && !mode_q[6]);
    assign nirq_nxt = fire ? (mode_q[7] ? ~mode_q[10] : 1'b0) : mode_q[10];
    assign strobe   = mode_q[10] && !nirq_nxt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q   <= '0;
        tgt_q   <= '0;
        mode_q  <= MW'(13'h0400);
        fired_q <= 1'b0;
        irq_q   <= 1'b0;
      end else begin
        irq_q <= strobe && !wbusy;
        if (rd_mode) mode_q[12:11] <= 2'b00;
        if (wbusy) begin
          case (sel_reg)
            2'd0: cnt_q <= bus_wdata[CW-1:0];
            2'd1: begin
              mode_q[9:0] <= bus_wdata[9:0];
              if (bus_wdata[10]) mode_q[10] <= 1'b1;
              cnt_q   <= '0;
              fired_q <= 1'b0;
            end
            default: tgt_q <= bus_wdata[CW-1:0];
          endcase
        end else if (tick[g]) begin
          cnt_q <= (at_tgt && mode_q[3]) ? '0 : nxt;
          if (at_tgt) mode_q[11] <= 1'b1;
          if (wrap)   mode_q[12] <= 1'b1;
          mode_q[10] <= mode_q[7] ? nirq_nxt : 1'b1;
          if (fire && !mode_q[6]) fired_q <= 1'b1;
        end
      end
    end

    assign cnt_v[g]   = cnt_q;
    assign tgt_v[g]   = tgt_q;
    assign mode_v[g]  = mode_q;
    assign irq_out[g] = irq_q;
  end

  logic [CW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NCH; i++) begin
      if (sel_ch == 2'(i)) begin
        case (sel_reg)
          2'd0:    rd_val = cnt_v[i];
          2'd1:    rd_val = CW'(mode_v[i]);
          2'd2:    rd_val = tgt_v[i];
          default: rd_val = '0;
        endcase
      end
    end
    if (drop) rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= DW'(rd_val);
  end
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk #(
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int AW = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sys_tick,
  input logic               pix_tick,
  input logic               hbl_tick,
  input logic               bus_valid,
  input logic               bus_write,
  input logic               bus_half,
  input logic [AW-1:0]      bus_addr,
  input logic [DW-1:0]      bus_rdata,
  input logic [2:0]         irq_out,
  input logic [2:0][CW-1:0] tgt_v,
  input logic [CW-1:0]      cnt2,
  input logic [12:0]        mode2
);
  wire unused_ok = ^{bus_addr[3:2], bus_addr[0]};

  assert_rd_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && bus_half && bus_addr[1] |=> bus_rdata == '0);

  assert_wr_upper_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_half && bus_addr[1] |=> $stable(tgt_v));

  assert_ch3_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && bus_addr[5:4] == 2'd3 |=> bus_rdata == '0);

  assert_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write |=> bus_rdata[DW-1:CW] == '0);

  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode2[0] && (mode2[2:1] == 2'd0 || mode2[2:1] == 2'd3) && !(bus_valid && bus_write)
    |=> $stable(cnt2));

  assert_irq0_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out[0] |-> $past(sys_tick || pix_tick));

  assert_irq1_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out[1] |-> $past(sys_tick || hbl_tick));

  assert_irq2_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out[2] |-> $past(sys_tick));
endmodule

bind timer_bank timer_bank_chk #(.CW(CW), .DW(DW), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .pix_tick(pix_tick),
  .hbl_tick(hbl_tick), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_half(bus_half), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .irq_out(irq_out), .tgt_v(tgt_v), .cnt2(cnt_v[2]), .mode2(mode_v[2])
);

// File: tb/test_timer_bank.sv
`timescale 1ns/1ps
module test_timer_bank;
  logic clk = 0, rst_n = 0;
  logic sys_tick = 0, pix_tick = 0, hbl_tick = 0;
  logic bus_valid = 0, bus_write = 0, bus_half = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_out;

  int total = 0, bad = 0;
  int pulses [3];
  logic [31:0] rv;

  always #5 clk = ~clk;

  timer_bank i_timer_bank (
    .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .pix_tick(pix_tick),
    .hbl_tick(hbl_tick), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always @(negedge clk)
    if (rst_n) for (int i = 0; i < 3; i++) if (irq_out[i]) pulses[i]++;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(int ch, int rg, logic [31:0] d, bit half = 0, bit up = 0);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_half = half;
    bus_addr = {2'(ch), 2'(rg), up, 1'b0}; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_half = 0;
  endtask

  task automatic rd(int ch, int rg, output logic [31:0] d, input bit half = 0, bit up = 0);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_half = half;
    bus_addr = {2'(ch), 2'(rg), up, 1'b0};
    @(negedge clk);
    bus_valid = 0; bus_half = 0;
    d = bus_rdata;
  endtask

  task automatic ticks(int src, int n);
    @(negedge clk);
    case (src) 0: sys_tick = 1; 1: pix_tick = 1; default: hbl_tick = 1; endcase
    repeat (n) @(negedge clk);
    sys_tick = 0; pix_tick = 0; hbl_tick = 0;
    @(negedge clk);
  endtask

  task automatic clr_pulses();
    for (int i = 0; i < 3; i++) pulses[i] = 0;
  endtask

  task automatic t_reset();
    chk("R11 irq_out", 32'(irq_out), 0);
    rd(0, 1, rv); chk("R11 mode0", rv, 32'h0400);
    rd(2, 0, rv); chk("R11 count2", rv, 0);
    rd(1, 2, rv); chk("R11 target1", rv, 0);
  endtask

  task automatic t_decode();
    wr(0, 2, 32'h1111); wr(1, 2, 32'h2222); wr(2, 2, 32'h3333);
    rd(0, 2, rv); chk("R1 tgt0", rv, 32'h1111);
    rd(1, 2, rv); chk("R1 tgt1", rv, 32'h2222);
    rd(2, 2, rv); chk("R1 tgt2", rv, 32'h3333);
    wr(0, 0, 32'h0055); rd(0, 0, rv); chk("R1 cnt0", rv, 32'h0055);
    wr(2, 2, 32'hDEAD4321); rd(2, 2, rv); chk("R2 low half kept", rv, 32'h4321);
  endtask

  task automatic t_half();
    wr(1, 2, 32'h00AA, 1, 0); rd(1, 2, rv); chk("R3 half low write", rv, 32'hAA);
    wr(1, 2, 32'h5555, 1, 1); rd(1, 2, rv); chk("R3 upper write dropped", rv, 32'hAA);
    rd(1, 2, rv, 1, 1); chk("R3 upper read zero", rv, 0);
    wr(3, 2, 32'h0777); rd(3, 2, rv); chk("R4 channel 3 reads zero", rv, 0);
    wr(1, 3, 32'h0999); rd(1, 3, rv); chk("R4 reg 3 reads zero", rv, 0);
    rd(1, 2, rv); chk("R4 reg 3 write no effect", rv, 32'hAA);
  endtask

  task automatic t_sources();
    wr(0, 1, 32'h0100);
    ticks(0, 4); ticks(1, 5);
    rd(0, 0, rv); chk("R5 ch0 pixel only", rv, 5);
    wr(0, 1, 32'h0000);
    ticks(1, 3); ticks(0, 6);
    rd(0, 0, rv); chk("R5 ch0 system only", rv, 6);
    wr(1, 1, 32'h0100);
    ticks(0, 2); ticks(2, 7);
    rd(1, 0, rv); chk("R6 ch1 blank only", rv, 7);
  endtask

  task automatic t_prescale();
    wr(2, 1, 32'h0200);
    ticks(0, 20);
    rd(2, 0, rv); chk("R7 ch2 div8 of 20", rv, 2);
    ticks(0, 4);
    rd(2, 0, rv); chk("R7 ch2 remainder kept", rv, 3);
  endtask

  task automatic t_sync();
    wr(2, 1, 32'h0001); ticks(0, 5);
    rd(2, 0, rv); chk("R8 sync mode 0 halts", rv, 0);
    wr(2, 1, 32'h0007); ticks(0, 5);
    rd(2, 0, rv); chk("R8 sync mode 3 halts", rv, 0);
    wr(2, 1, 32'h0003); ticks(0, 5);
    rd(2, 0, rv); chk("R8 sync mode 1 runs", rv, 5);
    wr(2, 1, 32'h0005); ticks(0, 4);
    rd(2, 0, rv); chk("R8 sync mode 2 runs", rv, 4);
  endtask

  task automatic t_target();
    wr(0, 2, 32'd4); wr(0, 1, 32'h0058); clr_pulses();
    ticks(0, 12);
    chk("R10 repeat target pulses", 32'(pulses[0]), 3);
    chk("R10 other channels quiet", 32'(pulses[1] + pulses[2]), 0);
    rd(0, 0, rv); chk("R9 restart at target", rv, 0);
    rd(0, 1, rv); rd(0, 1, rv);
    wr(0, 1, 32'h0050); ticks(0, 6);
    rd(0, 0, rv); chk("R9 no restart runs past", rv, 6);
    rd(0, 1, rv); chk("R9 target flag", rv, 32'h0C50);
    rd(0, 1, rv); chk("R9 flag cleared by read", rv, 32'h0450);
  endtask

  task automatic t_oneshot();
    wr(1, 2, 32'd3); wr(1, 1, 32'h0018); clr_pulses();
    ticks(0, 12);
    chk("R10 one-shot single pulse", 32'(pulses[1]), 1);
  endtask

  task automatic t_wrap();
    wr(2, 2, 32'd0); wr(2, 1, 32'h0060); wr(2, 0, 32'hFFFE); clr_pulses();
    ticks(0, 3);
    rd(2, 0, rv); chk("R9 wrap count", rv, 1);
    chk("R10 wrap pulse", 32'(pulses[2]), 1);
    rd(2, 1, rv); chk("R9 wrap flag", rv, 32'h1460);
  endtask

  task automatic t_toggle();
    wr(0, 2, 32'd2); wr(0, 1, 32'h04D8); clr_pulses();
    ticks(0, 6);
    chk("R10 toggle pulses", 32'(pulses[0]), 2);
    rd(0, 1, rv); chk("R10 toggle line low", rv, 32'h08D8);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clr_pulses();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_decode();
    t_half();
    t_sources();
    t_prescale();
    t_sync();
    t_target();
    t_oneshot();
    t_wrap();
    t_toggle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule